// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Retained-Memory Controller

This block keeps the tap codes of several digitally controlled potentiometers and fronts a small modelled retained (non-volatile) byte array. The array holds one start-up code per wiper, a few general-purpose bytes and one reserved byte. A serial-bus engine in front of it hands over single-byte read and write requests, a pulse for a clean end of transfer, and a pulse for a transfer that ended without one. A volatile steering byte decides whether wiper-address accesses reach both the live wiper and its stored start-up code, or only the live wiper.

Writes to retained bytes are held pending until a clean end of transfer. Then a self-timed programming cycle runs for a fixed number of clocks, during which the block reports busy and ignores requests. While the supply is not good, every wiper sits at mid-scale. When the supply becomes good, the stored start-up codes are copied into the wipers. The wiper codes go out on one flat bus to the analog ladder.

Top module: `dpot_regfile`

## Requirements
- R1: While `supply_ok` is low, `busy` is high one clock later, every wiper reads 80h and the steering byte returns to 00h. Requests made in that state are ignored.
- R2: On the first clock edge with `supply_ok` high after reset or after a supply loss, each wiper i loads stored byte i, and `busy` is low after that edge.
- R3: After `rst_n`, stored bytes 0 to 3 hold 80h, stored bytes 4 to 7 hold 00h, and the steering byte (address 8) holds 00h.
- R4: With the steering byte at 00h, a write to address i (0 to 3) changes wiper i on the next clock and arms a pending retained write. A read of address i returns stored byte i.
- R5: With the steering byte at 80h, a write to address i (0 to 3) changes wiper i only, and a read of address i returns wiper i. The stored byte is left as it was.
- R6: A write to address 8 takes effect only for the values 00h and 80h. Writes to address 7 and to addresses 9 to 15 are ignored and never start a programming cycle. Reads of address 8 return the steering byte, reads of address 7 return stored byte 7, and reads of addresses 9 to 15 return 00h.
- R7: Addresses 4 to 6 are reachable only with the steering byte at 00h. With the byte at 80h, writes there are ignored and reads there return 00h.
- R8: A `bus_stop` pulse while a retained write is pending holds `busy` high for exactly `NV_CYCLES` clocks, then the target byte holds the data. When several writes come before the stop, the last one wins.
- R9: A `bus_stop` with no pending retained write, such as after a read or a volatile-only write, leaves `busy` low.
- R10: A `bus_abort` pulse discards the pending retained write, so a later `bus_stop` starts no cycle and the stored byte keeps its value.
- R11: While `busy` is high, requests are ignored, `rd_data` holds its value, and with the supply good the wiper codes do not change.
- R12: Read data appears on `rd_data` one clock after an accepted read request and holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads factory contents |
| supply_ok | input | 1 | Supply-good indication; low means powered down |
| req_valid | input | 1 | Byte request strobe, one clock per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Byte address: 0-3 wipers, 4-6 general purpose, 7 reserved, 8 steering |
| req_wdata | input | DW (8) | Write data |
| bus_stop | input | 1 | Clean end-of-transfer pulse |
| bus_abort | input | 1 | Transfer ended without a clean stop |
| rd_data | output | DW (8) | Registered read data |
| busy | output | 1 | High while powered down, recalling or programming |
| wiper_codes | output | N_WIPER*DW (32) | Wiper i at bits [8i+7:8i] |

## Verification
The hardest state to reach is a recall that visibly differs from the reset values. This needs stored bytes that are no longer 80h, live wipers that differ from those bytes, and then a supply loss without a reset. The stimulus programs two start-up codes through full programming cycles. It then moves two other wipers through volatile-only and aborted writes, drops `supply_ok`, and checks both the mid-scale hold and the mixed set of recalled codes. Requests made during a programming cycle and during the powered-down state are also issued, to show that neither leaves a trace.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;
  typedef enum logic [1:0] {
    SEQ_DOWN = 2'd0,
    SEQ_IDLE = 2'd1,
    SEQ_PROG = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dpot_seq.sv
`timescale 1ns/1ps
// Power / programming sequencer: recall on supply good, timed retained write.
module dpot_seq #(
  parameter int NV_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic arm,
  input  logic stop,
  input  logic abort,
  output logic busy,
  output logic recall,
  output logic prog_done,
  output logic prog_active,
  output logic pending
);
  import dpot_pkg::*;
  localparam int CW = (NV_CYCLES > 2) ? $clog2(NV_CYCLES) : 1;

  seq_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           pend_q, pend_d;
  logic           cnt_en;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pend_d    = pend_q;
    recall    = 1'b0;
    prog_done = 1'b0;
    case (state_q)
      SEQ_DOWN: begin
        pend_d = 1'b0;
        if (supply_ok) begin
          state_d = SEQ_IDLE;
          recall  = 1'b1;
        end
      end
      SEQ_IDLE: begin
        if (abort)    pend_d = 1'b0;
        else if (arm) pend_d = 1'b1;
        if (stop && pend_q) begin
          state_d = SEQ_PROG;
          cnt_d   = CW'(NV_CYCLES - 1);
        end
      end
      SEQ_PROG: begin
        if (cnt_q == '0) begin
          state_d   = SEQ_IDLE;
          prog_done = 1'b1;
          pend_d    = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = SEQ_DOWN;
    endcase
    if (!supply_ok) begin
      state_d   = SEQ_DOWN;
      pend_d    = 1'b0;
      recall    = 1'b0;
      prog_done = 1'b0;
    end
  end

  assign cnt_en = (state_d == SEQ_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_DOWN;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy        = (state_q != SEQ_IDLE);
  assign prog_active = (state_q == SEQ_PROG);
  assign pending     = pend_q;
endmodule

// File: rtl/dpot_nvmem.sv
`timescale 1ns/1ps
// Modelled retained byte array with one pending-write slot.
module dpot_nvmem #(
  parameter int NV_BYTES = 8,
  parameter int DW       = 8,
  parameter int N_IVR    = 4,
  parameter logic [DW-1:0] FACTORY = 8'h80,
  localparam int AW = $clog2(NV_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic [AW-1:0]          arm_addr,
  input  logic [DW-1:0]          arm_data,
  input  logic                   commit,
  output logic [NV_BYTES*DW-1:0] nv_flat
);
  logic [AW-1:0] pa_q;
  logic [DW-1:0] pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      pd_q <= '0;
    end else if (arm) begin
      pa_q <= arm_addr;
      pd_q <= arm_data;
    end
  end

  for (genvar g = 0; g < NV_BYTES; g++) begin : g_cell
    logic [DW-1:0] cell_q;
    logic          cell_we;
    assign cell_we = commit && (pa_q == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= (g < N_IVR) ? FACTORY : '0;
      else if (cell_we) cell_q <= pd_q;
    end
    assign nv_flat[g*DW +: DW] = cell_q;
  end
endmodule

// File: rtl/dpot_wipers.sv
`timescale 1ns/1ps
// Bank of live wiper registers: mid-scale hold, recall, direct write.
module dpot_wipers #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] MID = 8'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_mid,
  input  logic            recall,
  input  logic [N*DW-1:0] ivr_flat,
  input  logic [N-1:0]    wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [N*DW-1:0] wiper_flat
);
  for (genvar i = 0; i < N; i++) begin : g_wiper
    logic [DW-1:0] w_q, w_d;
    logic          w_en;
    always_comb begin
      w_en = hold_mid || recall || wr_en[i];
      if (hold_mid)    w_d = MID;
      else if (recall) w_d = ivr_flat[i*DW +: DW];
      else             w_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= MID;
      else if (w_en) w_q <= w_d;
    end
    assign wiper_flat[i*DW +: DW] = w_q;
  end
endmodule

// File: rtl/dpot_regfile.sv
`timescale 1ns/1ps
module dpot_regfile #(
  parameter int N_WIPER   = 4,
  parameter int DW        = 8,
  parameter int NV_BYTES  = 8,
  parameter int ADDR_W    = 4,
  parameter int NV_CYCLES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  supply_ok,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DW-1:0]         req_wdata,
  input  logic                  bus_stop,
  input  logic                  bus_abort,
  output logic [DW-1:0]         rd_data,
  output logic                  busy,
  output logic [N_WIPER*DW-1:0] wiper_codes
);
  localparam int NV_AW = $clog2(NV_BYTES);
  localparam int WI_AW = $clog2(N_WIPER);
  localparam logic [ADDR_W-1:0] A_GP  = ADDR_W'(N_WIPER);
  localparam logic [ADDR_W-1:0] A_RSV = ADDR_W'(NV_BYTES - 1);
  localparam logic [ADDR_W-1:0] A_STR = ADDR_W'(NV_BYTES);
  localparam logic [DW-1:0] STEER_BOTH = '0;
  localparam logic [DW-1:0] STEER_VOL  = DW'(1) << (DW - 1);

  logic [NV_BYTES*DW-1:0] nv_flat;
  logic [DW-1:0]          nv [NV_BYTES];
  logic [DW-1:0]          wip [N_WIPER];
  logic [N_WIPER-1:0]     wip_we;
  logic [DW-1:0]          acr_q, acr_d, rd_q, rd_d;
  logic acc_wr, acc_rd, vol_only, is_wiper, is_gp, is_rsv, is_str;
  logic arm, acr_we, recall, prog_done, prog_active, nv_pending;

  assign acc_wr   = req_valid && !busy &&  req_write;
  assign acc_rd   = req_valid && !busy && !req_write;
  assign vol_only = (acr_q == STEER_VOL);
  assign is_wiper = (req_addr < A_GP);
  assign is_gp    = (req_addr >= A_GP) && (req_addr < A_RSV);
  assign is_rsv   = (req_addr == A_RSV);
  assign is_str   = (req_addr == A_STR);
  assign arm      = acc_wr && !vol_only && (is_wiper || is_gp);
  assign acr_we   = acc_wr && is_str && (req_wdata == STEER_BOTH || req_wdata == STEER_VOL);

  for (genvar i = 0; i < N_WIPER; i++) begin : g_wdec
    assign wip_we[i] = acc_wr && (req_addr == ADDR_W'(i));
    assign wip[i]    = wiper_codes[i*DW +: DW];
  end
  for (genvar b = 0; b < NV_BYTES; b++) begin : g_nv
    assign nv[b] = nv_flat[b*DW +: DW];
  end

  dpot_seq #(.NV_CYCLES(NV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .arm(arm),
    .stop(bus_stop), .abort(bus_abort), .busy(busy), .recall(recall),
    .prog_done(prog_done), .prog_active(prog_active), .pending(nv_pending)
  );

  dpot_nvmem #(.NV_BYTES(NV_BYTES), .DW(DW), .N_IVR(N_WIPER), .FACTORY(STEER_VOL)) u_nv (
    .clk(clk), .rst_n(rst_n), .arm(arm), .arm_addr(req_addr[NV_AW-1:0]),
    .arm_data(req_wdata), .commit(prog_done), .nv_flat(nv_flat)
  );

  dpot_wipers #(.N(N_WIPER), .DW(DW), .MID(STEER_VOL)) u_wip (
    .clk(clk), .rst_n(rst_n), .hold_mid(!supply_ok), .recall(recall),
    .ivr_flat(nv_flat[N_WIPER*DW-1:0]), .wr_en(wip_we), .wr_data(req_wdata),
    .wiper_flat(wiper_codes)
  );

  // steering byte
  always_comb begin
    acr_d = acr_q;
    if (!supply_ok)  acr_d = STEER_BOTH;
    else if (acr_we) acr_d = req_wdata;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acr_q <= STEER_BOTH;
    else        acr_q <= acr_d;
  end

  // read path
  always_comb begin
    rd_d = '0;
    if (is_wiper)    rd_d = vol_only ? wip[req_addr[WI_AW-1:0]] : nv[req_addr[NV_AW-1:0]];
    else if (is_gp)  rd_d = vol_only ? '0 : nv[req_addr[NV_AW-1:0]];
    else if (is_rsv) rd_d = nv[req_addr[NV_AW-1:0]];
    else if (is_str) rd_d = acr_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (acc_rd) rd_q <= rd_d;
  end
  assign rd_data = rd_q;
endmodule

// File: rtl/dpot_regfile_chk.sv
`timescale 1ns/1ps
module dpot_regfile_chk #(
  parameter int N_WIPER = 4,
  parameter int DW      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  supply_ok,
  input logic                  req_valid,
  input logic                  req_write,
  input logic                  bus_stop,
  input logic                  busy,
  input logic [DW-1:0]         rd_data,
  input logic [N_WIPER*DW-1:0] wiper_codes,
  input logic [DW-1:0]         acr_q,
  input logic                  prog_active,
  input logic                  nv_pending
);
  localparam logic [DW-1:0] MIDV = DW'(1) << (DW - 1);

  // R1
  down_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (busy && wiper_codes == {N_WIPER{MIDV}}));

  // R6
  steer_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acr_q == '0) || (acr_q == MIDV));

  // R11
  prog_wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_active && supply_ok) |=> $stable(wiper_codes));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write && !busy) |=> $stable(rd_data));

  // R9
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_stop && !nv_pending && supply_ok) |=> !busy);
endmodule

bind dpot_regfile dpot_regfile_chk #(.N_WIPER(N_WIPER), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .req_valid(req_valid),
  .req_write(req_write), .bus_stop(bus_stop), .busy(busy), .rd_data(rd_data),
  .wiper_codes(wiper_codes), .acr_q(acr_q), .prog_active(prog_active),
  .nv_pending(nv_pending)
);

// File: tb/tb_dpot_regfile.sv
`timescale 1ns/1ps
module tb_dpot_regfile;
  localparam int NVC = 12;
  logic clk = 1'b0;
  logic rst_n, supply_ok, req_valid, req_write, bus_stop, bus_abort;
  logic [3:0]  req_addr;
  logic [7:0]  req_wdata, rd_data;
  logic        busy;
  logic [31:0] wiper_codes;
  int checks = 0, errors = 0;
  logic fire_q = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  dpot_regfile #(.NV_CYCLES(NVC)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_stop(bus_stop), .bus_abort(bus_abort), .rd_data(rd_data),
    .busy(busy), .wiper_codes(wiper_codes)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) fire_q <= rst_n && req_valid && !req_write && !busy;
  always @(negedge clk) if (fire_q) begin
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R12: unexpected read data actual=%0h expected=none", rd_data);
    end else begin
      logic [7:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(t, rd_data, e);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask
  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask
  task automatic rd_nocheck(input logic [3:0] a);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask
  task automatic pulse_stop();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic pulse_abort();
    bus_abort = 1; @(negedge clk); bus_abort = 0;
  endtask
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask
  task automatic idle_after_stop(input string t);
    pulse_stop();
    for (int k = 0; k < 3; k++) begin chk(t, busy, 0); @(negedge clk); end
  endtask
  function automatic logic [7:0] wp(input int i);
    return wiper_codes[i*8 +: 8];
  endfunction

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; supply_ok = 0; req_valid = 0; req_write = 0; req_addr = 0;
    req_wdata = 0; bus_stop = 0; bus_abort = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: powered down
    chk("R1 busy while down", busy, 1);
    chk("R1 wipers mid while down", wiper_codes, 32'h80808080);
    wr(4'd0, 8'h55);
    chk("R1 write ignored while down", wp(0), 8'h80);
    supply_ok = 1;
    @(negedge clk);
    chk("R2 busy low after recall", busy, 0);
    chk("R2 recall factory codes", wiper_codes, 32'h80808080);
    idle_after_stop("R1 down write left nothing pending");
    for (int i = 0; i < 4; i++) rd(4'(i), 8'h80, "R3 factory start code");
    rd(4'd4, 8'h00, "R3 general byte reset");
    rd(4'd8, 8'h00, "R3 steering reset");
    // R4 / R8
    wr(4'd1, 8'h3C);
    chk("R4 wiper1 written", wp(1), 8'h3C);
    rd(4'd1, 8'h80, "R4 read returns stored value before stop");
    pulse_stop();
    busy_len(n);
    chk("R8 program length", n, NVC);
    rd(4'd1, 8'h3C, "R8 stored value after program");
    wr(4'd5, 8'hA7); wr(4'd5, 8'h5B);
    pulse_stop(); busy_len(n);
    chk("R8 second program length", n, NVC);
    rd(4'd5, 8'h5B, "R8 last write wins");
    // R6 / R5
    wr(4'd8, 8'h80);
    rd(4'd8, 8'h80, "R6 steering accepts 80h");
    wr(4'd8, 8'h33);
    rd(4'd8, 8'h80, "R6 steering rejects 33h");
    wr(4'd2, 8'hC4);
    chk("R5 volatile wiper write", wp(2), 8'hC4);
    rd(4'd2, 8'hC4, "R5 read returns wiper");
    rd(4'd1, 8'h3C, "R5 read wiper1");
    idle_after_stop("R9 stop after volatile write");
    wr(4'd6, 8'h11);
    rd(4'd6, 8'h00, "R7 general byte hidden");
    idle_after_stop("R7 hidden write arms nothing");
    wr(4'd8, 8'h00);
    rd(4'd6, 8'h00, "R7 hidden write had no effect");
    rd(4'd2, 8'h80, "R5 stored byte untouched");
    // R6 reserved / out of range
    wr(4'd7, 8'hEE);
    idle_after_stop("R6 reserved write no program");
    rd(4'd7, 8'h00, "R6 reserved read");
    wr(4'd12, 8'h99);
    rd(4'd12, 8'h00, "R6 out-of-range read");
    // R10 abort
    wr(4'd0, 8'h9A);
    chk("R10 wiper0 still written", wp(0), 8'h9A);
    pulse_abort();
    idle_after_stop("R10 abort discards");
    rd(4'd0, 8'h80, "R10 stored byte unchanged");
    // R11 busy ignores requests
    wr(4'd3, 8'h21);
    pulse_stop();
    chk("R11 busy after stop", busy, 1);
    wr(4'd3, 8'h77);
    rd_nocheck(4'd0);
    chk("R11 wiper unchanged while busy", wp(3), 8'h21);
    chk("R11 rd_data held while busy", rd_data, 8'h80);
    busy_len(n);
    rd(4'd3, 8'h21, "R11 program used first data");
    // R1 / R2 power cycle
    supply_ok = 0;
    @(negedge clk);
    chk("R1 mid on supply loss", wiper_codes, 32'h80808080);
    chk("R1 busy on supply loss", busy, 1);
    wr(4'd8, 8'h80);
    supply_ok = 1;
    @(negedge clk);
    chk("R2 recall programmed codes", wiper_codes, 32'h21803C80);
    rd(4'd8, 8'h00, "R1 steering cleared by supply loss");
    repeat (3) @(negedge clk);
    chk("R12 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule